// File: doc/BRIEF.md
# Wake Event Detection and Latch Controller

This block watches up to 64 external wake sources for a power-management controller and turns qualified activity on them into a wake request. The sources are grouped in two banks of 32. Each source has an enable bit and a polarity bit. The block records every enabled source that fired in a sticky primary status register. A second, software-side status register is filled only while a latch-enable control bit is high. That window lets firmware catch events that arrive while the chip is still coming out of a low-power state.

Firmware reaches the block through a small register port. Reads return data one cycle after the request. Writes take effect at the clock edge. Every input passes through a two-flop synchronizer. A build parameter picks the detection variant. With edge detection, a synchronized transition in the chosen direction fires the source. With level detection, the source fires in every cycle in which its synchronized value matches the chosen polarity.

Top module: `wake_latch_ctrl`

## Requirements
- R1: After reset, every register reads as zero and wake_req is low.
- R2: A source whose enable bit is 0 never sets a bit in either status register and never raises wake_req.
- R3: In the edge variant, a polarity bit of 1 fires the source on a synchronized 0-to-1 transition and a polarity bit of 0 fires it on a 1-to-0 transition. The opposite transition and a steady input do nothing.
- R4: In the level variant, the source fires in every cycle while its synchronized input equals its polarity bit. Clearing its status bit while the input stays active does not leave the bit at zero.
- R5: Source n belongs to bank n/32 at bit n%32. Bank 0 uses offsets 0x0C (enable), 0x10 (polarity), 0x14 (status) and 0x18 (software status). Bank 1 uses 0x160, 0x164, 0x168 and 0x16C for the same roles.
- R6: A primary status bit stays set until it is cleared by a write. Writing to a status register clears each bit whose written value is 0 and keeps each bit whose written value is 1.
- R7: Bit 5 of the control register at 0x00 opens the latch window. While that bit is 1, fired sources also set software status bits. Once it has been written back to 0, the software status register is updated by register writes only.
- R8: When a source fires in the same cycle as a write that would clear its status bit, the bit ends up set.
- R9: wake_req is high in the cycle after any enabled source fires, and low otherwise. In the edge variant, wake_req rises at the third rising clock edge after an input change.
- R10: A read returns its data on the rising edge that samples the request, and bus_rdata holds the previous value until that edge. Unmapped offsets read as zero, and writes to them change nothing.
- R11: The enable and polarity registers keep their written values through latch-enable changes and status writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wake_in | input | 2*DATA_W | Raw wake source inputs, bit n is source n |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid one cycle after bus_rd |
| wake_req | output | 1 | Wake request, high one cycle per firing |

## Verification
The hardest case to reach from the ports is a source firing in exactly the same cycle as a status-clearing write, because the firing happens several flops behind the input. The bench counts the two synchronizer stages and the edge-compare register from the input change. It then raises the clearing write so that its edge coincides with the cycle in which the detection is live. Two instances, one per detection variant, share every input, so a single stimulus sequence shows how edge and level behaviour differ on the same source.

// File: rtl/wake_pkg.sv
package wake_pkg;
    localparam int NUM_BANKS = 2;
    localparam int LATCH_BIT = 5;
    localparam int OFS_CTRL = 'h000;
    localparam int OFS_MASK [NUM_BANKS] = '{'h00C, 'h160};
    localparam int OFS_LVL  [NUM_BANKS] = '{'h010, 'h164};
    localparam int OFS_STAT [NUM_BANKS] = '{'h014, 'h168};
    localparam int OFS_SWST [NUM_BANKS] = '{'h018, 'h16C};
endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t r_d, r_q;

    always_comb begin
        r_d    = r_q;
        r_d.s1 = din;
        r_d.s2 = r_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign dout = r_q.s2;
endmodule

// File: rtl/wake_detect.sv
module wake_detect #(
    parameter int W           = 64,
    parameter bit DETECT_EDGE = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] hit
);
    logic [W-1:0] cur;
    logic [W-1:0] qual;

    wake_sync #(.W(W)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (din),
        .dout (cur)
    );

    if (DETECT_EDGE) begin : g_edge
        logic [W-1:0] prev_d, prev_q;
        always_comb prev_d = cur;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= '0;
            else        prev_q <= prev_d;
        end
        // rising when polarity is 1, falling when polarity is 0
        assign qual = (cur & ~prev_q & lvl) | (~cur & prev_q & ~lvl);
    end else begin : g_level
        assign qual = ~(cur ^ lvl);
    end

    assign hit = qual & mask;
endmodule

// File: rtl/wake_latch_ctrl.sv
module wake_latch_ctrl
    import wake_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 9,
    parameter bit DETECT_EDGE = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2*DATA_W-1:0] wake_in,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                wake_req
);
    localparam int NSRC = NUM_BANKS * DATA_W;
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);

    typedef struct packed {
        logic              latch;
        logic [NSRC-1:0]   mask;
        logic [NSRC-1:0]   lvl;
        logic [NSRC-1:0]   stat;
        logic [NSRC-1:0]   swst;
        logic [DATA_W-1:0] rdata;
        logic              req;
    } state_t;

    state_t            r_d, r_q;
    logic [NSRC-1:0]   hit;
    logic [NSRC-1:0]   stat_keep;
    logic [NSRC-1:0]   sw_keep;
    logic [DATA_W-1:0] rd_val;

    // checker taps
    logic [NSRC-1:0] mask_w, stat_w, swst_w;
    logic            latch_w;

    wake_detect #(.W(NSRC), .DETECT_EDGE(DETECT_EDGE)) u_det (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (wake_in),
        .mask (r_q.mask),
        .lvl  (r_q.lvl),
        .hit  (hit)
    );

    always_comb begin
        r_d       = r_q;
        stat_keep = '1;
        sw_keep   = '1;
        rd_val    = '0;

        if (bus_addr == A_CTRL) begin
            if (bus_wr) r_d.latch = bus_wdata[LATCH_BIT];
            rd_val[LATCH_BIT] = r_q.latch;
        end

        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bus_addr == ADDR_W'(OFS_MASK[b])) begin
                if (bus_wr) r_d.mask[b*DATA_W +: DATA_W] = bus_wdata;
                rd_val = r_q.mask[b*DATA_W +: DATA_W];
            end
            if (bus_addr == ADDR_W'(OFS_LVL[b])) begin
                if (bus_wr) r_d.lvl[b*DATA_W +: DATA_W] = bus_wdata;
                rd_val = r_q.lvl[b*DATA_W +: DATA_W];
            end
            if (bus_addr == ADDR_W'(OFS_STAT[b])) begin
                if (bus_wr) stat_keep[b*DATA_W +: DATA_W] = bus_wdata;
                rd_val = r_q.stat[b*DATA_W +: DATA_W];
            end
            if (bus_addr == ADDR_W'(OFS_SWST[b])) begin
                if (bus_wr) sw_keep[b*DATA_W +: DATA_W] = bus_wdata;
                rd_val = r_q.swst[b*DATA_W +: DATA_W];
            end
        end

        // a firing source overrides a clear in the same cycle
        r_d.stat = (r_q.stat & stat_keep) | hit;
        r_d.swst = (r_q.swst & sw_keep) | (r_q.latch ? hit : '0);
        r_d.req  = |hit;
        if (bus_rd) r_d.rdata = rd_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign bus_rdata = r_q.rdata;
    assign wake_req  = r_q.req;
    assign mask_w    = r_q.mask;
    assign stat_w    = r_q.stat;
    assign swst_w    = r_q.swst;
    assign latch_w   = r_q.latch;
endmodule

// File: rtl/wake_latch_chk.sv
module wake_latch_chk
    import wake_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 9
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       bus_wr,
    input logic                       bus_rd,
    input logic [ADDR_W-1:0]          bus_addr,
    input logic [DATA_W-1:0]          bus_rdata,
    input logic                       wake_req,
    input logic [NUM_BANKS*DATA_W-1:0] mask,
    input logic [NUM_BANKS*DATA_W-1:0] stat,
    input logic [NUM_BANKS*DATA_W-1:0] swst,
    input logic                       latch
);
    logic mapped;
    always_comb begin
        mapped = (bus_addr == ADDR_W'(OFS_CTRL));
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bus_addr == ADDR_W'(OFS_MASK[b]) || bus_addr == ADDR_W'(OFS_LVL[b]) ||
                bus_addr == ADDR_W'(OFS_STAT[b]) || bus_addr == ADDR_W'(OFS_SWST[b]))
                mapped = 1'b1;
        end
    end

    AST_REQ_HAS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> (stat != '0)); // R9

    AST_MASK_GATES_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat & ~$past(stat) & ~$past(mask)) == '0)); // R2

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> ((~stat & $past(stat)) == '0)); // R6

    AST_SW_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!latch && !bus_wr) |=> $stable(swst)); // R7

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !mapped) |=> (bus_rdata == '0)); // R10
endmodule

bind wake_latch_ctrl wake_latch_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .bus_rdata(bus_rdata),
    .wake_req (wake_req),
    .mask     (mask_w),
    .stat     (stat_w),
    .swst     (swst_w),
    .latch    (latch_w)
);

// File: tb/sim_wake_latch_ctrl.sv
module sim_wake_latch_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] wake_in = '0;
    logic        wr = 1'b0, rd = 1'b0;
    logic [8:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata0, rdata1;
    logic        req0, req1;
    int          n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;

    wake_latch_ctrl #(.DETECT_EDGE(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .wake_in(wake_in), .bus_wr(wr), .bus_rd(rd),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata0), .wake_req(req0));
    wake_latch_ctrl #(.DETECT_EDGE(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .wake_in(wake_in), .bus_wr(wr), .bus_rd(rd),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata1), .wake_req(req1));

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr_reg(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk); wr = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1; wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [8:0] a, output logic [31:0] d0, output logic [31:0] d1);
        @(negedge clk); rd = 1'b1; addr = a;
        @(posedge clk); #1; d0 = rdata0; d1 = rdata1; rd = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic t_reset;
        logic [31:0] a, b;
        logic [8:0] offs [9] = '{9'h000, 9'h00C, 9'h010, 9'h014, 9'h018,
                                 9'h160, 9'h164, 9'h168, 9'h16C};
        for (int i = 0; i < 9; i++) begin
            rd_reg(offs[i], a, b);
            chk("R1 edge reg zero", a, 0);
            chk("R1 level reg zero", b, 0);
        end
        chk("R1 req low", {30'b0, req1, req0}, 0);
    endtask

    task automatic t_mask;
        logic [31:0] a, b;
        logic seen = 1'b0;
        wr_reg(9'h010, 32'h8);
        @(negedge clk); wake_in[3] = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(posedge clk); #1;
            if (req0 || req1) seen = 1'b1;
        end
        chk("R2 no req when disabled", {31'b0, seen}, 0);
        rd_reg(9'h014, a, b);
        chk("R2 edge status stays 0", a, 0);
        chk("R2 level status stays 0", b, 0);
        @(negedge clk); wake_in[3] = 1'b0;
        wait_cyc(4);
    endtask

    task automatic t_req_timing;
        logic [31:0] a, b;
        wr_reg(9'h00C, 32'h8);
        @(negedge clk); wake_in[3] = 1'b1;
        @(posedge clk); #1; chk("R9 req low edge 1", {31'b0, req0}, 0);
        @(posedge clk); #1; chk("R9 req low edge 2", {31'b0, req0}, 0);
        @(posedge clk); #1; chk("R9 req high edge 3", {31'b0, req0}, 1);
        @(posedge clk); #1; chk("R9 req low edge 4", {31'b0, req0}, 0);
        rd_reg(9'h014, a, b);
        chk("R3 rising fires polarity 1", a, 32'h8);
    endtask

    task automatic t_polarity;
        logic [31:0] a, b;
        wr_reg(9'h00C, 32'h18);
        wr_reg(9'h014, 32'h0);
        @(negedge clk); wake_in[3] = 1'b0; wake_in[4] = 1'b1;
        wait_cyc(5);
        rd_reg(9'h014, a, b);
        chk("R3 opposite transitions ignored", a, 0);
        @(negedge clk); wake_in[4] = 1'b0;
        wait_cyc(5);
        rd_reg(9'h014, a, b);
        chk("R3 falling fires polarity 0", a, 32'h10);
    endtask

    task automatic t_clear;
        logic [31:0] a, b;
        @(negedge clk); wake_in[3] = 1'b1;
        wait_cyc(5);
        rd_reg(9'h014, a, b);
        chk("R6 sticky both bits", a, 32'h18);
        wr_reg(9'h014, 32'hFFFF_FFEF);
        rd_reg(9'h014, a, b);
        chk("R6 clear only zero bits", a, 32'h8);
        wr_reg(9'h014, 32'h0);
        rd_reg(9'h014, a, b);
        chk("R6 clear all", a, 0);
    endtask

    task automatic t_bank2;
        logic [31:0] a, b;
        wr_reg(9'h164, 32'h100);
        wr_reg(9'h160, 32'h100);
        @(negedge clk); wake_in[40] = 1'b1;
        wait_cyc(5);
        rd_reg(9'h168, a, b);
        chk("R5 source 40 in bank 1 bit 8", a, 32'h100);
        rd_reg(9'h014, a, b);
        chk("R5 bank 0 untouched", a, 0);
        rd_reg(9'h160, a, b);
        chk("R5 bank 1 enable readback", a, 32'h100);
    endtask

    task automatic t_latch;
        logic [31:0] a, b;
        rd_reg(9'h16C, a, b);
        chk("R7 no capture outside window", a, 0);
        wr_reg(9'h000, 32'h20);
        rd_reg(9'h000, a, b);
        chk("R7 latch bit readback", a, 32'h20);
        @(negedge clk); wake_in[40] = 1'b0;
        wait_cyc(4);
        @(negedge clk); wake_in[40] = 1'b1;
        wait_cyc(5);
        rd_reg(9'h16C, a, b);
        chk("R7 capture inside window", a, 32'h100);
        wr_reg(9'h000, 32'h0);
        wr_reg(9'h16C, 32'h0);
        @(negedge clk); wake_in[40] = 1'b0;
        wait_cyc(4);
        @(negedge clk); wake_in[40] = 1'b1;
        wait_cyc(5);
        rd_reg(9'h16C, a, b);
        chk("R7 frozen after window closes", a, 0);
        rd_reg(9'h168, a, b);
        chk("R7 primary still records", a, 32'h100);
    endtask

    task automatic t_cfg_kept;
        logic [31:0] a, b;
        rd_reg(9'h010, a, b);
        chk("R11 bank 0 polarity kept", a, 32'h8);
        rd_reg(9'h164, a, b);
        chk("R11 bank 1 polarity kept", a, 32'h100);
        rd_reg(9'h00C, a, b);
        chk("R11 bank 0 enable kept", a, 32'h18);
    endtask

    task automatic t_collision;
        logic [31:0] a, b;
        @(negedge clk); wake_in[3] = 1'b0;
        wait_cyc(4);
        wr_reg(9'h014, 32'h0);
        @(negedge clk); wake_in[3] = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk); wr = 1'b1; addr = 9'h014; wdata = 32'h0;
        @(posedge clk); #1; wr = 1'b0;
        rd_reg(9'h014, a, b);
        chk("R8 event beats clear", a, 32'h8);
    endtask

    task automatic t_read_path;
        logic [31:0] a, b;
        rd_reg(9'h004, a, b);
        chk("R10 unmapped reads zero", a, 0);
        wr_reg(9'h01C, 32'hFFFF_FFFF);
        rd_reg(9'h01C, a, b);
        chk("R10 unmapped write ignored", a, 0);
        rd_reg(9'h00C, a, b);
        chk("R10 mapped reg unaffected", a, 32'h18);
        @(negedge clk); rd = 1'b1; addr = 9'h000;
        #1; chk("R10 data held before edge", rdata0, 32'h18);
        @(posedge clk); #1; rd = 1'b0;
        chk("R10 data after edge", rdata0, 0);
    endtask

    task automatic t_level;
        logic [31:0] a, b;
        wr_reg(9'h010, 32'h20);
        wr_reg(9'h00C, 32'h20);
        wait_cyc(3);
        wr_reg(9'h014, 32'h0);
        rd_reg(9'h014, a, b);
        chk("R4 inactive level no status", b, 0);
        @(negedge clk); wake_in[5] = 1'b1;
        wait_cyc(5);
        rd_reg(9'h014, a, b);
        chk("R4 active level sets status", b, 32'h20);
        wr_reg(9'h014, 32'h0);
        rd_reg(9'h014, a, b);
        chk("R4 held level re-sets status", b, 32'h20);
        chk("R3 edge variant stays cleared", a, 0);
        @(negedge clk); wake_in[5] = 1'b0;
        wait_cyc(4);
        wr_reg(9'h014, 32'h0);
        rd_reg(9'h014, a, b);
        chk("R4 released level clears", b, 0);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #800_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        wait_cyc(2);
        t_reset();
        t_mask();
        t_req_timing();
        t_polarity();
        t_clear();
        t_bank2();
        t_latch();
        t_cfg_kept();
        t_collision();
        t_read_path();
        t_level();
        summary();
    end
endmodule